// File: doc/BRIEF.md
# Teletext Bit Request and Insertion Interface

This block connects an external serial teletext source to a video line generator that runs on the 27 MHz line-locked clock. On every line that configuration marks as a text line, it opens an insertion window at a programmable horizontal position. Inside the window a phase accumulator paces the bit slots at the text bit rate of the selected standard. Each slot is requested from the source on `req_o`. After a programmable number of clock cycles, one bit is sampled from `ttx_i`. The sampled bits leave the block on `bit_o`, each qualified by a one-cycle `bit_vld_o` strobe for the downstream waveform shaper.

Two request handshakes are available. The first gives one short request pulse per bit. The second raises the request once and holds it high for the whole window. The window closes after exactly the number of bits that the chosen standard defines, whatever the line timing does in the meantime. Text lines are picked with one mask for the first field and a separate mask for the second field.

Top module: `ttx_req_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `req_o`, `bit_vld_o` and `bit_o` are 0 until a window opens.
- R2: The cycle after `line_start_i` is high, the horizontal count is 0. On a selected line, the window opens in the cycle in which that count equals `hstart_i`, and `req_o` or the first slot follows from there.
- R3: Bit slots come from a 16-bit accumulator. The accumulator is cleared when the window opens and adds an increment every cycle the window is open. The increment is 16839 for `std_sel_i` = 0 and 13901 for codes 1, 2 and 3. Each carry out of bit 15 is one slot. The first add happens in the cycle after the window opens.
- R4: With `proto_i` = 0, `req_o` is high for exactly one cycle per slot, in the cycle after the carry.
- R5: With `proto_i` = 1, `req_o` rises once, in the cycle after the window opens, and stays high through the pulse cycle of the last slot.
- R6: `ttx_i` is sampled `delay_i` cycles (0 to 15) after the request pulse cycle of each slot. The sampled bit appears on `bit_o`, with `bit_vld_o` high for one cycle, one cycle later.
- R7: A window holds exactly 360 slots for code 0 (625-line WST), 296 for code 1 (525-line WST), and 288 for codes 2 and 3 (NABTS).
- R8: Bit k of `mask_f0_i` selects line index k when `field_i` = 0, and bit k of `mask_f1_i` selects it when `field_i` = 1. Line indices of 32 or more are never selected. On an unselected line, `req_o` and `bit_vld_o` stay low.
- R9: A `line_start_i` that arrives while a window is open does not shorten that window. A horizontal count match during an open window does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz line-locked clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| field_i | input | 1 | Current field: 0 first, 1 second |
| line_idx_i | input | 10 | Line number within the field |
| mask_f0_i | input | 32 | Text line selection for the first field |
| mask_f1_i | input | 32 | Text line selection for the second field |
| hstart_i | input | 11 | Horizontal count at which the window opens |
| std_sel_i | input | 2 | Text standard code (see R3 and R7) |
| proto_i | input | 1 | 0: one pulse per bit; 1: held window request |
| delay_i | input | 4 | Cycles from request pulse to sampling |
| ttx_i | input | 1 | Serial text bit from the source |
| req_o | output | 1 | Bit request to the source |
| bit_o | output | 1 | Sampled text bit |
| bit_vld_o | output | 1 | Strobe qualifying `bit_o` |

## Verification
A new request pulse and the delayed sampling of an earlier slot can fall in the same cycle. This happens whenever `delay_i` is at least as long as the slot spacing, which is roughly four cycles at the 625-line rate. Directed runs with delay 15 on that standard, together with random delays, make several samples pending in the delay line while fresh pulses are issued. Every cycle is compared against the slot schedule computed in the bench, so a lost or shifted sample shows up as a mismatch on `bit_vld_o` or `bit_o` in that exact cycle.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int ACC_W = 16;
  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    STD_WST625 = 2'd0,
    STD_WST525 = 2'd1,
    STD_NABTS  = 2'd2,
    STD_NABTS2 = 2'd3
  } ttx_std_e;

  function automatic logic [CNT_W-1:0] win_len(ttx_std_e s);
    case (s)
      STD_WST625: win_len = CNT_W'(360);
      STD_WST525: win_len = CNT_W'(296);
      default:    win_len = CNT_W'(288);
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] bit_inc(ttx_std_e s);
    if (s == STD_WST625) bit_inc = ACC_W'(16839);
    else                 bit_inc = ACC_W'(13901);
  endfunction
endpackage

// File: rtl/ttx_hcount.sv
module ttx_hcount #(
  parameter int HCNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [HCNT_W-1:0] hstart_i,
  input  logic              sel_i,
  input  logic              busy_i,
  output logic              open_o
);
  localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};

  logic [HCNT_W-1:0] hcnt_q;
  logic              armed_q;
  logic              hit;

  assign hit    = armed_q && !line_start_i && (hcnt_q == hstart_i);
  assign open_o = hit && sel_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= HMAX;
      armed_q <= 1'b0;
    end else if (line_start_i) begin
      hcnt_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (hcnt_q != HMAX) hcnt_q <= hcnt_q + 1'b1;
      if (hit) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ttx_bit_clock.sv
module ttx_bit_clock
  import ttx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             active_o,
  output logic             slot_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, slot_q, carry;

  assign sum   = {1'b0, acc_q} + {1'b0, inc_i};
  assign carry = active_q && sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      slot_q   <= 1'b0;
    end else begin
      slot_q <= carry;
      if (open_i) begin
        active_q <= 1'b1;
        acc_q    <= '0;
        cnt_q    <= '0;
      end else if (active_q) begin
        acc_q <= sum[ACC_W-1:0];
        if (carry) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == limit_i - 1'b1) active_q <= 1'b0;
        end
      end
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/ttx_sample.sv
module ttx_sample #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             ttx_i,
  output logic             bit_o,
  output logic             vld_o
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH-1:0] sr_q;
  logic             tap;

  // pending slots age through the line; delay picks the tap
  assign tap = (delay_i == '0) ? slot_i : sr_q[delay_i - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      sr_q  <= {sr_q[DEPTH-2:0], slot_i};
      vld_o <= tap;
      if (tap) bit_o <= ttx_i;
    end
  end
endmodule

// File: rtl/ttx_req_ctrl.sv
module ttx_req_ctrl
  import ttx_pkg::*;
#(
  parameter int HCNT_W = 11,
  parameter int LINE_W = 10,
  parameter int NLINES = 32,
  parameter int DLY_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              field_i,
  input  logic [LINE_W-1:0] line_idx_i,
  input  logic [NLINES-1:0] mask_f0_i,
  input  logic [NLINES-1:0] mask_f1_i,
  input  logic [HCNT_W-1:0] hstart_i,
  input  logic [1:0]        std_sel_i,
  input  logic              proto_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              ttx_i,
  output logic              req_o,
  output logic              bit_o,
  output logic              bit_vld_o
);
  localparam int IDX_W = $clog2(NLINES);

  logic [NLINES-1:0] mask;
  logic              in_range, sel, open_w, active_w, slot_w;
  logic [CNT_W-1:0]  cnt_w, limit;
  logic [ACC_W-1:0]  inc;

  assign mask     = field_i ? mask_f1_i : mask_f0_i;
  assign in_range = (line_idx_i < LINE_W'(NLINES));
  assign sel      = in_range && mask[line_idx_i[IDX_W-1:0]];
  assign limit    = win_len(ttx_std_e'(std_sel_i));
  assign inc      = bit_inc(ttx_std_e'(std_sel_i));

  ttx_hcount #(.HCNT_W(HCNT_W)) u_hcount (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .hstart_i     (hstart_i),
    .sel_i        (sel),
    .busy_i       (active_w),
    .open_o       (open_w)
  );

  ttx_bit_clock u_bitclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open_w),
    .inc_i    (inc),
    .limit_i  (limit),
    .active_o (active_w),
    .slot_o   (slot_w),
    .cnt_o    (cnt_w)
  );

  ttx_sample #(.DLY_W(DLY_W)) u_sample (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot_w),
    .delay_i (delay_i),
    .ttx_i   (ttx_i),
    .bit_o   (bit_o),
    .vld_o   (bit_vld_o)
  );

  assign req_o = proto_i ? (active_w | slot_w) : slot_w;
endmodule

// File: rtl/ttx_req_chk.sv
module ttx_req_chk
  import ttx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             proto_i,
  input logic [1:0]       std_sel_i,
  input logic             req_o,
  input logic             bit_vld_o,
  input logic             active_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] lim;
  assign lim = win_len(ttx_std_e'(std_sel_i));

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proto_i && req_o) |=> !req_o);

  p_held_request_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_i && active_q) |-> req_o);

  p_vld_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < lim));

  p_close_at_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> (cnt_q == lim));

  p_open_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> (cnt_q == '0));
endmodule

bind ttx_req_ctrl ttx_req_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .proto_i   (proto_i),
  .std_sel_i (std_sel_i),
  .req_o     (req_o),
  .bit_vld_o (bit_vld_o),
  .active_q  (active_w),
  .cnt_q     (cnt_w)
);

// File: tb/ttx_req_ctrl_bench.sv
module ttx_req_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        field = 1'b0;
  logic [9:0]  line_idx = '0;
  logic [31:0] mask_f0 = 32'h0000_0080;
  logic [31:0] mask_f1 = 32'h0000_0100;
  logic [10:0] hstart = '0;
  logic [1:0]  std_sel = '0;
  logic        proto = 1'b0;
  logic [3:0]  delay = '0;
  logic        ttx = 1'b0;
  logic        req, bit_out, bit_vld;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ttx_req_ctrl u_ttx_req_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .field_i(field),
    .line_idx_i(line_idx), .mask_f0_i(mask_f0), .mask_f1_i(mask_f1),
    .hstart_i(hstart), .std_sel_i(std_sel), .proto_i(proto), .delay_i(delay),
    .ttx_i(ttx), .req_o(req), .bit_o(bit_out), .bit_vld_o(bit_vld)
  );

  function automatic int ref_inc(int s);
    return (s == 0) ? 16839 : 13901;
  endfunction

  function automatic int ref_len(int s);
    return (s == 0) ? 360 : (s == 1) ? 296 : 288;
  endfunction

  function automatic int last_j(int s);
    return (ref_len(s) * 65536 + ref_inc(s) - 1) / ref_inc(s);
  endfunction

  function automatic bit is_carry(int s, int j);
    if (j < 1 || j > last_j(s)) return 1'b0;
    return ((j * ref_inc(s)) >> 16) != (((j - 1) * ref_inc(s)) >> 16);
  endfunction

  function automatic logic pat(int c);
    int unsigned h;
    h = c * 32'h9E37_79B1;
    return h[17];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one line start, then a cycle-accurate comparison over the whole window
  task automatic run_win(input int sd, input int pr, input int dl, input int hs,
                         input int fl, input int ln, input bit opn, input int mid,
                         input string tag);
    int t0, s, j, span, nreq, nvld;
    bit er, ev, pend;
    @(negedge clk);
    std_sel = 2'(sd); proto = pr[0]; delay = 4'(dl); hstart = 11'(hs);
    field = fl[0]; line_idx = 10'(ln); line_start = 1'b1;
    t0 = cyc;
    s = t0 + 1 + hs;
    span = s + last_j(sd) + dl + 25;
    nreq = 0; nvld = 0;
    for (int c = t0 + 1; c <= span; c++) begin
      @(negedge clk);
      j = c - s;
      pend = opn && is_carry(sd, j - 1);
      er = pr ? (opn && j >= 1 && j <= last_j(sd) + 1) : pend;
      ev = opn && is_carry(sd, j - 2 - dl);
      if (pend) nreq++;
      if (bit_vld) nvld++;
      check(pr ? {tag, " R2/R3/R5 req"} : {tag, " R2/R3/R4 req"}, req, er);
      check({tag, " R6 vld"}, bit_vld, ev);
      if (ev) check({tag, " R6 bit"}, bit_out, pat(c - 1));
      line_start = (mid > 0) && (c == t0 + mid);
      ttx = pat(c);
    end
    check_int({tag, " R7 slots"}, nreq, opn ? ref_len(sd) : 0);
    check_int({tag, " R7 samples"}, nvld, opn ? ref_len(sd) : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    check("R1 req in reset", req, 1'b0);
    check("R1 vld in reset", bit_vld, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 req after reset", req, 1'b0);
    check("R1 vld after reset", bit_vld, 1'b0);
    check("R1 bit after reset", bit_out, 1'b0);

    run_win(0, 0, 3, 10, 0, 7, 1'b1, 0, "625 pulse");
    run_win(1, 1, 0, 0, 1, 8, 1'b1, 0, "525 held");
    run_win(2, 0, 15, 5, 0, 7, 1'b1, 0, "nabts d15");
    run_win(0, 0, 15, 40, 0, 7, 1'b1, 0, "625 d15 overlap");
    run_win(3, 1, 7, 90, 1, 8, 1'b1, 0, "code3 held");
    run_win(0, 0, 2, 10, 1, 7, 1'b0, 0, "R8 field1 line7");
    run_win(1, 1, 2, 10, 0, 8, 1'b0, 0, "R8 field0 line8");
    mask_f0 = 32'hFFFF_FFFF;
    run_win(0, 1, 2, 10, 0, 40, 1'b0, 0, "R8 line40");
    run_win(0, 0, 4, 20, 0, 3, 1'b1, 200, "R9 mid line start");
    run_win(1, 1, 9, 5, 0, 3, 1'b1, 300, "R9 held mid line start");

    mask_f0 = 32'hA5C3_0F96;
    mask_f1 = 32'h5A3C_F069;
    for (int k = 0; k < 8; k++) begin
      int sd, pr, dl, hs, fl, ln;
      bit opn;
      sd = int'($urandom % 4);
      pr = int'($urandom % 2);
      dl = int'($urandom % 16);
      hs = int'($urandom % 300);
      fl = int'($urandom % 2);
      ln = int'($urandom % 36);
      opn = (ln < 32) && (fl != 0 ? mask_f1[ln] : mask_f0[ln]);
      run_win(sd, pr, dl, hs, fl, ln, opn, 0, "random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule